// File: doc/BRIEF.md
# Self-Correcting Four-Phase Ring Counter

This block turns one input clock into a set of non-overlapping phase signals. A shift register holds a single one, and that one moves one stage to the right on every clock. Each phase output is therefore high for exactly one clock period, and the phases take turns in a fixed order. With the default width of four, this gives the repeating pattern 1000, 0100, 0010, 0001 and then 1000 again.

The bit that enters the first stage is generated inside the block. It is 1 only when every stage except the last holds zero. In every other case it is 0, and the register simply shifts right. Because of this feedback, the counter repairs itself from any starting value, including power-up garbage or a corrupted state. It reaches the valid one-hot sequence within WIDTH clocks, and no external preset is needed.

A synchronous active-high reset loads the first phase pattern (1000). A seed port loads an arbitrary pattern into the register. It exists so that every possible starting state can be forced during test.

The next-state selector has three named states:
- SEL_RESET: load the first phase pattern.
- SEL_SEED: load `seed_val`.
- SEL_SHIFT: shift right, with the generated bit entering the first stage.

The named transitions are:
- rst taken: go to SEL_RESET.
- seed taken: go to SEL_SEED.
- idle rotate: go to SEL_SHIFT.

Top module: `ring_phase_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next value of `phase_o` is 1000 (bit 3 set, all other bits clear).
- R2: When `rst` and `seed_en` are both high at the same edge, the reset wins and `phase_o` becomes 1000.
- R3: When `seed_en` is high and `rst` is low at an edge, `phase_o` equals `seed_val` after that edge.
- R4: From a one-hot value, each edge without reset or seed rotates the pattern one place right. Bit 0 wraps around to bit 3, so the order is 1000, 0100, 0010, 0001, 1000.
- R5: Once the register is in the valid sequence, exactly one bit of `phase_o` is high in every cycle.
- R6: From the all-zero state, one edge without reset or seed gives 1000.
- R7: From any of the 16 possible register values, `phase_o` is one-hot after at most four edges without reset or seed.
- R8: On every edge without reset or seed, bits 2..0 of the new value equal bits 3..1 of the old value. The new bit 3 is 1 exactly when old bits 3..1 were all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock from which the phases are derived |
| rst | input | 1 | Synchronous active-high reset; loads 1000 |
| seed_en | input | 1 | Loads `seed_val` on the next edge (test preload) |
| seed_val | input | WIDTH | Pattern to load when `seed_en` is high |
| phase_o | output | WIDTH | Phase outputs; bit WIDTH-1 is the first phase |

## Verification
The bench builds the block with WIDTH left at 4. At that width the whole state space is 16 values, so every starting state is seeded through the preload port. The bench then checks the first recovery step, the one-hot condition at the fourth edge, and four further rotations. This covers both the all-zero injection case and the all-ones worst case for recovery time.

// File: rtl/ring_phase_pkg.sv
package ring_phase_pkg;

    // Selection of the register's next value
    typedef enum logic [1:0] {
        SEL_RESET = 2'd0,
        SEL_SEED  = 2'd1,
        SEL_SHIFT = 2'd2
    } next_sel_e;

endpackage

// File: rtl/ring_sel_ctrl.sv
module ring_sel_ctrl
    import ring_phase_pkg::*;
(
    input  logic      rst,
    input  logic      seed_en,
    output next_sel_e sel
);

    // Reset has priority over the seed load; otherwise the register rotates
    always_comb begin
        unique case ({rst, seed_en})
            2'b10, 2'b11: sel = SEL_RESET;  // rst taken
            2'b01:        sel = SEL_SEED;   // seed taken
            default:      sel = SEL_SHIFT;  // idle rotate
        endcase
    end

endmodule

// File: rtl/ring_inject.sv
module ring_inject #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] state,
    output logic             inject
);

    generate
        if (WIDTH > 1) begin : g_multi
            // A one enters only when all stages but the last are empty
            assign inject = ~|state[WIDTH-1:1];
        end else begin : g_single
            assign inject = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/ring_shift_reg.sv
module ring_shift_reg
    import ring_phase_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  next_sel_e        sel,
    input  logic [WIDTH-1:0] seed_val,
    input  logic             inject,
    output logic [WIDTH-1:0] state
);

    localparam logic [WIDTH-1:0] FIRST_PHASE = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] shifted;

    always_comb begin
        shifted            = state >> 1;
        shifted[WIDTH-1]   = inject;
    end

    always_ff @(posedge clk) begin
        unique case (sel)
            SEL_RESET: state <= FIRST_PHASE;
            SEL_SEED:  state <= seed_val;
            SEL_SHIFT: state <= shifted;
            default:   state <= state;
        endcase
    end

endmodule

// File: rtl/ring_phase_gen.sv
module ring_phase_gen
    import ring_phase_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_en,
    input  logic [WIDTH-1:0] seed_val,
    output logic [WIDTH-1:0] phase_o
);

    next_sel_e        sel;
    logic             inject;
    logic [WIDTH-1:0] state;

    ring_sel_ctrl u_ctrl (
        .rst     (rst),
        .seed_en (seed_en),
        .sel     (sel)
    );

    ring_inject #(.WIDTH(WIDTH)) u_inject (
        .state  (state),
        .inject (inject)
    );

    ring_shift_reg #(.WIDTH(WIDTH)) u_reg (
        .clk      (clk),
        .sel      (sel),
        .seed_val (seed_val),
        .inject   (inject),
        .state    (state)
    );

    assign phase_o = state;

endmodule

// File: rtl/ring_phase_chk.sv
module ring_phase_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             seed_en,
    input logic [WIDTH-1:0] seed_val,
    input logic [WIDTH-1:0] phase_o
);

    localparam int CW = $clog2(WIDTH + 1) + 1;
    localparam logic [WIDTH-1:0] FIRST_PHASE = {1'b1, {(WIDTH-1){1'b0}}};

    logic          seen = 1'b0;
    logic [CW-1:0] since_load = '0;

    // Count edges since the last reset or seed, saturating at WIDTH
    always_ff @(posedge clk) begin
        if (rst || seed_en) begin
            seen       <= 1'b1;
            since_load <= '0;
        end else if (since_load < CW'(WIDTH)) begin
            since_load <= since_load + 1'b1;
        end
    end

    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> (phase_o == FIRST_PHASE));

    assert_seed_load_R3: assert property (@(posedge clk) disable iff (rst)
        seed_en |=> (phase_o == $past(seed_val)));

    assert_rotate_R4: assert property (@(posedge clk) disable iff (rst)
        (seen && !seed_en && $onehot(phase_o))
        |=> (phase_o == {$past(phase_o[0]), $past(phase_o[WIDTH-1:1])}));

    assert_zero_inject_R6: assert property (@(posedge clk) disable iff (rst)
        (seen && !seed_en && phase_o == '0) |=> (phase_o == FIRST_PHASE));

    assert_recover_R7: assert property (@(posedge clk) disable iff (rst)
        (seen && since_load == CW'(WIDTH)) |-> $onehot(phase_o));

    assert_shift_R8: assert property (@(posedge clk) disable iff (rst)
        (seen && !seed_en) |=> (phase_o[WIDTH-2:0] == $past(phase_o[WIDTH-1:1])));

endmodule

bind ring_phase_gen ring_phase_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .seed_en  (seed_en),
    .seed_val (seed_val),
    .phase_o  (phase_o)
);

// File: tb/ring_phase_gen_tb.sv
module ring_phase_gen_tb;

    localparam int W = 4;

    typedef enum logic [1:0] {K_EXACT, K_ONEHOT, K_ROT, K_NOTE} kind_e;
    typedef struct {
        kind_e          kind;
        logic [W-1:0]   val;
        string          tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         seed_en = 1'b0;
    logic [W-1:0] seed_val = '0;
    logic [W-1:0] phase_o;

    item_t        sb[$];
    logic [W-1:0] last_seen = '0;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ring_phase_gen #(.WIDTH(W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .seed_en  (seed_en),
        .seed_val (seed_val),
        .phase_o  (phase_o)
    );

    // Driver: set inputs for the next edge and queue what it should produce
    task automatic cycle(input logic r, input logic s_en, input logic [W-1:0] s,
                         input kind_e k, input logic [W-1:0] v, input string tag);
        item_t it;
        @(negedge clk);
        rst      = r;
        seed_en  = s_en;
        seed_val = s;
        it.kind  = k;
        it.val   = v;
        it.tag   = tag;
        sb.push_back(it);
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: phase_o=%b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: compare the result of each edge against the queued item
    always begin
        item_t it;
        logic [W-1:0] rot;
        @(posedge clk);
        #2;
        if (sb.size() > 0) begin
            it  = sb.pop_front();
            rot = {last_seen[0], last_seen[W-1:1]};
            case (it.kind)
                K_EXACT: check(it.tag, phase_o, it.val);
                K_ONEHOT: begin
                    checks++;
                    if (!$onehot(phase_o)) begin
                        errors++;
                        $display("FAIL %s: phase_o=%b expected one-hot", it.tag, phase_o);
                    end
                end
                K_ROT: begin
                    check(it.tag, phase_o, rot);
                    checks++;
                    if (!$onehot(phase_o)) begin  // R5
                        errors++;
                        $display("FAIL R5: phase_o=%b expected one-hot", phase_o);
                    end
                end
                default: ;
            endcase
            last_seen = phase_o;
        end
    end

    initial begin
        logic [W-1:0] first;
        // R1: reset loads 1000
        cycle(1'b1, 1'b0, '0, K_EXACT, 4'b1000, "R1");
        cycle(1'b1, 1'b0, '0, K_EXACT, 4'b1000, "R1");
        // R4: rotation order from the reset pattern
        cycle(1'b0, 1'b0, '0, K_EXACT, 4'b0100, "R4");
        cycle(1'b0, 1'b0, '0, K_EXACT, 4'b0010, "R4");
        cycle(1'b0, 1'b0, '0, K_EXACT, 4'b0001, "R4");
        cycle(1'b0, 1'b0, '0, K_EXACT, 4'b1000, "R4");
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, '0, K_ROT, '0, "R4");
        // R2: reset beats seed
        cycle(1'b1, 1'b1, 4'b0110, K_EXACT, 4'b1000, "R2");
        // Every starting state
        for (int s = 0; s < 16; s++) begin
            first = (s[3:1] == 3'b000) ? {1'b1, s[3:1]} : {1'b0, s[3:1]};
            cycle(1'b0, 1'b1, W'(s), K_EXACT, W'(s), "R3");
            cycle(1'b0, 1'b0, '0, K_EXACT, first, (s == 0) ? "R6" : "R8");
            cycle(1'b0, 1'b0, '0, K_NOTE, '0, "R7");
            cycle(1'b0, 1'b0, '0, K_NOTE, '0, "R7");
            cycle(1'b0, 1'b0, '0, K_ONEHOT, '0, "R7");
            for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, '0, K_ROT, '0, "R4");
        end
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule